// File: doc/BRIEF.md
# Cartridge Bank-Switching Register File

This block is the write-only register file of a game cartridge. It watches the CPU bus and, on each write strobe into the upper half of the address space, loads one of a small set of narrow registers. From those registers it produces the upper program ROM address bits for the CPU access in progress, the 9-bit character ROM bank for the PPU pattern fetch in progress, and the A10 line that selects a nametable page.

Each 4 KB region from 0x8000 to 0xFFFF holds up to four registers. The two address lines that form the 2-bit register index within a region are chosen by the `WIRING` parameter, so that one design serves boards that route different CPU address lines, some of them in swapped order. All other low address lines are ignored, so every register appears at many addresses. Writes to the top region (0xF000-0xFFFF) load nothing here. They are passed on, with their decoded index, to a separate interrupt timer.

The program windows are 8 KB each. A mode bit swaps the first window with the fixed second-to-last bank. Each character window is 1 KB, and its bank number is put together from a 4-bit low register and a 5-bit high register.

Top module: `cart_bank_regs`

## Requirements
- R1: After reset every bank register, the mirroring field and the mode bit are zero: windows 0x8000 and 0xA000 give bank 0, 0xC000 gives PRG_BANKS-2, 0xE000 gives PRG_BANKS-1, every character window gives 0, and mirroring is vertical.
- R2: The register index is {cpu_addr[P1], cpu_addr[P0]}. WIRING 0..5 selects (P0,P1) = (1,2), (1,0), (6,7), (3,2), (2,3), (0,1). The other bits of cpu_addr[11:0] have no effect on which register is written.
- R3: A write with cpu_addr[15:12] = 0x8 loads program register 0 from cpu_data[4:0]. A write with cpu_addr[15:12] = 0xA loads program register 1 from cpu_data[4:0].
- R4: In region 0x9, index 0 or 1 loads the mirroring field from cpu_data[1:0], and index 2 or 3 loads the mode bit from cpu_data[1].
- R5: With mode 0 the windows selected by cpu_addr[14:13] = 0,1,2,3 give register 0, register 1, PRG_BANKS-2 and PRG_BANKS-1.
- R6: With mode 1, window 0 gives PRG_BANKS-2 and window 2 gives register 0. Windows 1 and 3 are the same as in mode 0.
- R7: In region 0xB+k (k = 0..3), index 0 loads the low 4 bits and index 1 the high 5 bits of character window 2k. Index 2 loads the low bits and index 3 the high bits of window 2k+1.
- R8: The character bank for the window selected by ppu_addr[12:10] is {high5, low4}. For example, high 1 and low 3 give 0x13.
- R9: nt_a10 is ppu_addr[10] when mirroring is 00 (vertical), ppu_addr[11] when it is 01 (horizontal), 0 when it is 10, and 1 when it is 11.
- R10: irq_wr is high exactly while cpu_wr is high with cpu_addr[15:12] = 0xF, and irq_sel then carries the decoded index. Such writes change no register in this block.
- R11: While cpu_wr is low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe; registers load at the rising clock edge |
| ppu_addr | input | 14 | PPU address |
| prg_bank | output | 5 | 8 KB program bank for the window cpu_addr[14:13] |
| chr_bank | output | 9 | 1 KB character bank for the window ppu_addr[12:10] |
| nt_a10 | output | 1 | Nametable page select |
| irq_wr | output | 1 | Write strobe forwarded to the interrupt timer |
| irq_sel | output | 2 | Decoded register index for the forwarded write |

## Verification
The bench drives bytes with junk in their upper bits, to catch a design that keeps too many data bits. It writes through addresses full of bits that are not index bits, to catch decoding of lines that should be ignored. It runs a second instance whose index lines are swapped, where a fixed decoder would load the wrong register half. It toggles the mode bit both ways and reads all four program windows, which exposes a swap applied to the wrong window. It sets all eight character banks to distinct values, so a mixed-up low/high pairing or window numbering shows up as a wrong bank. It also checks that writes to the timer region and idle cycles with a live address leave every output unchanged.

// File: rtl/cart_bank_regs.sv
module cart_bank_regs #(
  parameter int WIRING    = 0,
  parameter int PRG_BANKS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  input  logic [13:0] ppu_addr,
  output logic [4:0]  prg_bank,
  output logic [8:0]  chr_bank,
  output logic        nt_a10,
  output logic        irq_wr,
  output logic [1:0]  irq_sel
);

  function automatic int line_of(int w, int b);
    case (w)
      1:       return b ? 0 : 1;
      2:       return b ? 7 : 6;
      3:       return b ? 2 : 3;
      4:       return b ? 3 : 2;
      5:       return b ? 1 : 0;
      default: return b ? 2 : 1;
    endcase
  endfunction

  localparam int P0 = line_of(WIRING, 0);
  localparam int P1 = line_of(WIRING, 1);
  localparam logic [4:0] SECOND = 5'(PRG_BANKS - 2);
  localparam logic [4:0] LAST   = 5'(PRG_BANKS - 1);

  logic [4:0] prg0, prg1;
  logic [1:0] mir;
  logic       mode;
  logic [3:0] chr_lo [8];
  logic [4:0] chr_hi [8];

  logic [3:0] region;
  logic [1:0] idx;
  logic [2:0] cwin;

  assign region = cpu_addr[15:12];
  assign idx    = {cpu_addr[P1], cpu_addr[P0]};
  assign cwin   = {region[1:0] + 2'b01, idx[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg0 <= '0;
      prg1 <= '0;
      mir  <= '0;
      mode <= 1'b0;
      for (int i = 0; i < 8; i++) begin
        chr_lo[i] <= '0;
        chr_hi[i] <= '0;
      end
    end else if (cpu_wr) begin
      case (region)
        4'h8: prg0 <= cpu_data[4:0];
        4'h9: if (idx[1]) mode <= cpu_data[1];
              else        mir  <= cpu_data[1:0];
        4'hA: prg1 <= cpu_data[4:0];
        4'hB, 4'hC, 4'hD, 4'hE:
              if (idx[0]) chr_hi[cwin] <= cpu_data[4:0];
              else        chr_lo[cwin] <= cpu_data[3:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cpu_addr[14:13])
      2'd0:    prg_bank = mode ? SECOND : prg0;
      2'd1:    prg_bank = prg1;
      2'd2:    prg_bank = mode ? prg0 : SECOND;
      default: prg_bank = LAST;
    endcase
  end

  assign chr_bank = {chr_hi[ppu_addr[12:10]], chr_lo[ppu_addr[12:10]]};

  always_comb begin
    case (mir)
      2'd0:    nt_a10 = ppu_addr[10];
      2'd1:    nt_a10 = ppu_addr[11];
      2'd2:    nt_a10 = 1'b0;
      default: nt_a10 = 1'b1;
    endcase
  end

  assign irq_wr  = cpu_wr && (region == 4'hF);
  assign irq_sel = idx;

endmodule

// File: rtl/cart_bank_regs_chk.sv
module cart_bank_regs_chk #(
  parameter int PRG_BANKS = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_data,
  input logic        cpu_wr,
  input logic [13:0] ppu_addr,
  input logic [1:0]  idx,
  input logic [4:0]  prg0,
  input logic [4:0]  prg1,
  input logic [1:0]  mir,
  input logic        mode,
  input logic [4:0]  prg_bank,
  input logic        nt_a10,
  input logic        irq_wr
);

  // R3
  prg0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr[15:12] == 4'h8 |=> prg0 == $past(cpu_data[4:0]));

  // R4
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr[15:12] == 4'h9 && idx[1] |=> mode == $past(cpu_data[1]));

  // R5
  last_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:13] == 3'b111 |-> prg_bank == 5'(PRG_BANKS - 1));

  // R6
  swap_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode && cpu_addr[15:13] == 3'b100 |-> prg_bank == 5'(PRG_BANKS - 2));

  // R9
  single_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mir == 2'd2 |-> !nt_a10);

  // R9
  vert_mir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mir == 2'd0 |-> nt_a10 == ppu_addr[10]);

  // R10
  irq_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr |-> cpu_wr && cpu_addr[15:12] == 4'hF);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr |=> $stable(prg0) && $stable(prg1) && $stable(mir) && $stable(mode));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(prg0) && $stable(prg1) && $stable(mir) && $stable(mode));

endmodule

bind cart_bank_regs cart_bank_regs_chk #(.PRG_BANKS(PRG_BANKS)) chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
  .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .idx(idx), .prg0(prg0), .prg1(prg1),
  .mir(mir), .mode(mode), .prg_bank(prg_bank), .nt_a10(nt_a10), .irq_wr(irq_wr)
);

// File: tb/cart_bank_regs_test.sv
`timescale 1ns/1ps
module cart_bank_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [4:0]  prg_bank, prg_bank_b;
  logic [8:0]  chr_bank, chr_bank_b;
  logic        nt_a10, nt_a10_b, irq_wr, irq_wr_b;
  logic [1:0]  irq_sel, irq_sel_b;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  cart_bank_regs #(.WIRING(0), .PRG_BANKS(32)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_bank(prg_bank),
    .chr_bank(chr_bank), .nt_a10(nt_a10), .irq_wr(irq_wr), .irq_sel(irq_sel));

  cart_bank_regs #(.WIRING(1), .PRG_BANKS(32)) uut_b (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_bank(prg_bank_b),
    .chr_bank(chr_bank_b), .nt_a10(nt_a10_b), .irq_wr(irq_wr_b), .irq_sel(irq_sel_b));

  function automatic logic [15:0] reg_addr(int w, logic [3:0] nib, logic [1:0] i);
    int p0, p1;
    logic [15:0] a;
    case (w)
      1: begin p0 = 1; p1 = 0; end
      2: begin p0 = 6; p1 = 7; end
      3: begin p0 = 3; p1 = 2; end
      4: begin p0 = 2; p1 = 3; end
      5: begin p0 = 0; p1 = 1; end
      default: begin p0 = 1; p1 = 2; end
    endcase
    a = {nib, 12'h000};
    a[p0] = i[0];
    a[p1] = i[1];
    return a;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic prg_at(logic [15:0] a, int exp, string req);
    cpu_addr = a; #1;
    check(req, prg_bank, exp);
  endtask

  task automatic chr_at(int win, int exp, string req);
    ppu_addr = 14'(win << 10); #1;
    check(req, chr_bank, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    prg_at(16'h8000, 0, "R1 win0");
    prg_at(16'hA000, 0, "R1 win1");
    prg_at(16'hC000, 30, "R1 win2");
    prg_at(16'hE000, 31, "R1 win3");
    for (int w = 0; w < 8; w++) chr_at(w, 0, "R1 chr");
    ppu_addr = 14'h2400; #1;
    check("R1 vertical", nt_a10, 1);
  endtask

  task automatic t_prg();
    wr(16'h8FF9, 8'hE7);
    wr(reg_addr(0, 4'hA, 2'd3), 8'h35);
    prg_at(16'h8000, 7, "R3 prg0");
    prg_at(16'hA000, 21, "R3 prg1");
    prg_at(16'hC000, 30, "R5 win2");
    prg_at(16'hE000, 31, "R5 win3");
    wr(reg_addr(0, 4'h9, 2'd2), 8'h02);
    prg_at(16'h8000, 30, "R6 win0");
    prg_at(16'hA000, 21, "R6 win1");
    prg_at(16'hC000, 7, "R6 win2");
    prg_at(16'hE000, 31, "R6 win3");
    wr(reg_addr(0, 4'h9, 2'd3), 8'hFD);
    prg_at(16'h8000, 7, "R4 mode clear");
    prg_at(16'hC000, 30, "R4 mode clear");
  endtask

  task automatic t_mirror();
    wr(reg_addr(0, 4'h9, 2'd0), 8'h01);
    ppu_addr = 14'h2800; #1; check("R9 horiz A11", nt_a10, 1);
    ppu_addr = 14'h2400; #1; check("R9 horiz A10", nt_a10, 0);
    prg_at(16'h8000, 7, "R4 mirror write keeps mode");
    wr(reg_addr(0, 4'h9, 2'd1), 8'hFE);
    ppu_addr = 14'h2C00; #1; check("R9 single A", nt_a10, 0);
    wr(reg_addr(0, 4'h9, 2'd0), 8'h03);
    ppu_addr = 14'h2000; #1; check("R9 single B", nt_a10, 1);
    wr(reg_addr(0, 4'h9, 2'd1), 8'h00);
    ppu_addr = 14'h2400; #1; check("R9 vertical", nt_a10, 1);
    ppu_addr = 14'h2800; #1; check("R9 vertical", nt_a10, 0);
  endtask

  task automatic t_chr();
    for (int k = 0; k < 4; k++) begin
      wr(reg_addr(0, 4'(4'hB + k), 2'd0) | 16'h0F89, 8'(8'hF0 | (k + 1)));
      wr(reg_addr(0, 4'(4'hB + k), 2'd1), 8'(8'hE0 | (16 + k)));
      wr(reg_addr(0, 4'(4'hB + k), 2'd2), 8'(8'h50 | (8 + k)));
      wr(reg_addr(0, 4'(4'hB + k), 2'd3), 8'(8'hE0 | k));
    end
    for (int k = 0; k < 4; k++) begin
      chr_at(2 * k, ((16 + k) << 4) | (k + 1), "R7 even window");
      chr_at(2 * k + 1, (k << 4) | (8 + k), "R8 odd window");
    end
    wr(reg_addr(0, 4'hB, 2'd0), 8'h03);
    wr(reg_addr(0, 4'hB, 2'd1), 8'h01);
    chr_at(0, 9'h013, "R8 example");
  endtask

  task automatic t_irq_idle();
    @(negedge clk);
    cpu_addr = reg_addr(0, 4'hF, 2'd3); cpu_data = 8'hFF; cpu_wr = 1'b1; #1;
    check("R10 irq_wr", irq_wr, 1);
    check("R10 irq_sel", irq_sel, 3);
    @(negedge clk);
    cpu_addr = reg_addr(0, 4'hE, 2'd2); #1;
    check("R10 no forward", irq_wr, 0);
    cpu_wr = 1'b0;
    prg_at(16'h8000, 7, "R10 prg0 kept");
    prg_at(16'hA000, 21, "R10 prg1 kept");
    cpu_addr = 16'h8000; cpu_data = 8'h1F;
    @(negedge clk);
    cpu_addr = 16'h9004; cpu_data = 8'h03;
    @(negedge clk);
    prg_at(16'h8000, 7, "R11 idle prg0");
    prg_at(16'hC000, 30, "R11 idle mode");
    ppu_addr = 14'h2400; #1; check("R11 idle mirror", nt_a10, 1);
  endtask

  task automatic t_wiring();
    do_reset();
    wr(reg_addr(1, 4'hB, 2'd1) | 16'h0FFC, 8'h05);
    wr(reg_addr(1, 4'hB, 2'd2) | 16'h0FFC, 8'h0C);
    ppu_addr = 14'h0000; #1; check("R2 swapped lines hi", chr_bank_b, 9'h050);
    ppu_addr = 14'h0400; #1; check("R2 swapped lines lo", chr_bank_b, 9'h00C);
    @(negedge clk);
    cpu_addr = reg_addr(1, 4'hF, 2'd2); cpu_wr = 1'b1; #1;
    check("R2 swapped irq_sel", irq_sel_b, 2);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  initial begin
    t_reset();
    t_prg();
    t_mirror();
    t_chr();
    t_irq_idle();
    t_wiring();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #100000;
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule